// File: doc/BRIEF.md
# Step-of-five two-digit decimal counter

This block is a synchronous counter whose value is presented as two BCD digits and which moves forward by five each time its count enable is high at a clock edge. The value runs 00, 05, 10, 15 and so on up to 95, then returns to 00. A display driver or a comparator downstream reads the two digits directly, with no conversion.

The units position is not a decade counter. A single flip-flop holds it and toggles on every enabled count. Its state is decoded to the BCD digit 0 or 5. Each time that flip-flop falls from 1 to 0, it gives the carry into a BCD decade counter that holds the tens digit. The raw units bit and a flag that marks the top value are also brought out.

Internally, a small control module turns the reset, the enable and the current state into a struct of strobes. A datapath module holds the two registers and acts on those strobes.

Top module: `quint_bcd_counter`

## Requirements
- R1: Over a run of enabled cycles, the value 10*tens + units rises by exactly 5 per enabled cycle, modulo 100.
- R2: The raw units bit inverts on every clock edge where count enable is high and reset is low.
- R3: The units digit reads 4'b0000 when the raw units bit is 0 and 4'b0101 when it is 1.
- R4: The tens digit increases by one on an enabled edge where the units bit goes from 1 to 0. On an enabled edge where the units bit goes from 0 to 1, the tens digit is unchanged.
- R5: The tens digit only ever holds BCD codes 0 to 9, and it returns to 0 after 9.
- R6: An enabled count taken while the display shows 95 produces 00.
- R7: The terminal-count output is high exactly when the tens digit is 9 and the units bit is 1.
- R8: A synchronous reset clears the display to 00 on the next edge, even if count enable is high on that edge.
- R9: While count enable is low and reset is low, both digits and the units bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Advance the count by five on this edge |
| unitsDigit | output | 4 | BCD units digit, 0 or 5 |
| tensDigit | output | 4 | BCD tens digit, 0 to 9 |
| unitsBit | output | 1 | Raw state of the units flip-flop |
| termCount | output | 1 | High while the display reads 95 |

## Verification
A units flip-flop that misses a toggle puts the units digit out of step at the first enabled edge after the fault. The same error throws the tens digit off one edge later, because the carry then lands on the wrong count. A tens register that leaves BCD range shows a code above 9 at the port on the edge after 9. It also drops the terminal flag at 95, and both faults appear within twenty enabled counts of reset. The bench checks every digit after every step of a full lap, so any of these faults is reported on the cycle it first reaches the outputs.

// File: rtl/quint_pkg.sv
package quint_pkg;

  // Strobes from the control module to the datapath, valid for one edge.
  typedef struct packed {
    logic clear;   // return both positions to zero
    logic toggle;  // invert the units flip-flop
    logic carry;   // advance the tens digit
    logic wrap;    // tens digit returns from its top code to zero
  } ctrlStrobe_t;

endpackage

// File: rtl/quint_ctrl.sv
module quint_ctrl
  import quint_pkg::*;
(
  input  logic        rst,
  input  logic        countEn,
  input  logic        unitBit,
  input  logic        tensAtTop,
  output ctrlStrobe_t strobe
);

  logic stepOk;

  // Reset outranks count enable.
  assign stepOk = countEn & ~rst;

  always_comb begin
    strobe        = '0;
    strobe.clear  = rst;
    strobe.toggle = stepOk;
    // The units bit falling from 1 to 0 carries into the tens digit.
    strobe.carry  = stepOk & unitBit;
    strobe.wrap   = stepOk & unitBit & tensAtTop;
  end

  always_comb begin
    AST_CLEAR_BLOCKS_STEP: assert (!(strobe.clear && (strobe.toggle || strobe.carry))); // R8
    AST_WRAP_NEEDS_CARRY: assert (!strobe.wrap || strobe.carry); // R6
  end

endmodule

// File: rtl/quint_datapath.sv
module quint_datapath
  import quint_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int DIGIT_TOP = 9,
  parameter int HALF_CODE = 5
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobe,
  output logic               unitBit,
  output logic [DIGIT_W-1:0] tensVal,
  output logic [DIGIT_W-1:0] unitsVal,
  output logic               tensAtTop
);

  localparam logic [DIGIT_W-1:0] TOP_CODE  = DIGIT_W'(DIGIT_TOP);
  localparam logic [DIGIT_W-1:0] HALF_DISP = DIGIT_W'(HALF_CODE);
  localparam logic [DIGIT_W-1:0] ONE       = DIGIT_W'(1);

  logic               unitQ;
  logic [DIGIT_W-1:0] tensQ;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      unitQ <= 1'b0;
      tensQ <= '0;
    end else begin
      if (strobe.toggle) unitQ <= ~unitQ;
      if (strobe.wrap)       tensQ <= '0;
      else if (strobe.carry) tensQ <= tensQ + ONE;
    end
  end

  assign unitBit   = unitQ;
  assign tensVal   = tensQ;
  assign unitsVal  = unitQ ? HALF_DISP : '0;
  assign tensAtTop = (tensQ == TOP_CODE);

  AST_UNIT_TOGGLES: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.toggle |=> (unitQ != $past(unitQ))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.toggle |=> ($stable(unitQ) && $stable(tensQ))); // R9
  AST_TENS_STEP: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.carry && !strobe.wrap) |=> (tensQ == $past(tensQ) + ONE)); // R4
  AST_TENS_STILL: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.toggle && !unitQ) |=> $stable(tensQ)); // R4
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.toggle && unitQ && tensAtTop) |=> (tensQ == '0 && !unitQ)); // R6
  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.toggle |=> (tensQ <= TOP_CODE)); // R5

endmodule

// File: rtl/quint_bcd_counter.sv
module quint_bcd_counter
  import quint_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int DIGIT_TOP = 9,
  parameter int HALF_CODE = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countEn,
  output logic [DIGIT_W-1:0] unitsDigit,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic               unitsBit,
  output logic               termCount
);

  ctrlStrobe_t strobe;
  logic        unitBit;
  logic        tensAtTop;

  quint_ctrl i_ctrl (
    .rst      (rst),
    .countEn  (countEn),
    .unitBit  (unitBit),
    .tensAtTop(tensAtTop),
    .strobe   (strobe)
  );

  quint_datapath #(
    .DIGIT_W  (DIGIT_W),
    .DIGIT_TOP(DIGIT_TOP),
    .HALF_CODE(HALF_CODE)
  ) i_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .unitBit  (unitBit),
    .tensVal  (tensDigit),
    .unitsVal (unitsDigit),
    .tensAtTop(tensAtTop)
  );

  assign unitsBit  = unitBit;
  assign termCount = tensAtTop & unitBit; // R7

endmodule

// File: tb/test_quint_bcd_counter.sv
module test_quint_bcd_counter;

  logic       clk;
  logic       rst;
  logic       countEn;
  logic [3:0] unitsDigit;
  logic [3:0] tensDigit;
  logic       unitsBit;
  logic       termCount;

  int total;
  int bad;
  int model;  // expected value 0..95

  quint_bcd_counter i_quint_bcd_counter (
    .clk       (clk),
    .rst       (rst),
    .countEn   (countEn),
    .unitsDigit(unitsDigit),
    .tensDigit (tensDigit),
    .unitsBit  (unitsBit),
    .termCount (termCount)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (model=%0d)", req, what, act, exp, model);
    end
  endtask

  // Compare every port against the model value.
  task automatic checkAll(input string req);
    int expTens;
    int expBit;
    expTens = model / 10;
    expBit  = ((model % 10) == 5) ? 1 : 0;
    checkVal(req, "tensDigit", int'(tensDigit), expTens);
    checkVal(req, "unitsBit", int'(unitsBit), expBit);
    checkVal(req, "unitsDigit", int'(unitsDigit), expBit ? 5 : 0);
    checkVal(req, "termCount", int'(termCount), (model == 95) ? 1 : 0);
  endtask

  // Drive away from the edge, then sample just after it.
  task automatic edgeStep(input logic en, input logic r);
    @(negedge clk);
    countEn = en;
    rst     = r;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset;  // R8
    edgeStep(1'b0, 1'b1);
    edgeStep(1'b0, 1'b1);
    model = 0;
    checkAll("R8");
  endtask

  task automatic testSequence(input int n);  // R1 R2 R3 R4 R5 R7
    for (int i = 0; i < n; i++) begin
      edgeStep(1'b1, 1'b0);
      model = (model + 5) % 100;
      checkAll("R1/R2/R3/R4/R5/R7");
    end
  endtask

  task automatic testHold;  // R9
    for (int i = 0; i < 5; i++) begin
      edgeStep(1'b0, 1'b0);
      checkAll("R9");
    end
  endtask

  task automatic testWrap;  // R6 R7
    while (model != 90) begin
      edgeStep(1'b1, 1'b0);
      model = (model + 5) % 100;
    end
    checkAll("R7");
    edgeStep(1'b1, 1'b0);
    model = 95;
    checkAll("R7");
    edgeStep(1'b1, 1'b0);
    model = 0;
    checkAll("R6");
    edgeStep(1'b1, 1'b0);
    model = 5;
    checkAll("R6");
  endtask

  task automatic testResetPriority;  // R8
    testSequence(7);
    edgeStep(1'b1, 1'b1);
    model = 0;
    checkAll("R8");
    // Reset at an odd value, with enable high.
    edgeStep(1'b1, 1'b0);
    model = 5;
    edgeStep(1'b1, 1'b1);
    model = 0;
    checkAll("R8");
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total   = 0;
    bad     = 0;
    model   = 0;
    rst     = 1'b1;
    countEn = 1'b0;
    testReset();
    testSequence(13);
    testHold();
    testSequence(24);
    testHold();
    testWrap();
    testResetPriority();
    testSequence(40);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule